// File: doc/BRIEF.md
# Priority-Class Interrupt Acceptance Gate

This block sits between a set of interrupt sources and a processor core and decides whether a pending interrupt may be handed to the core. Every interrupt is named by an 8-bit vector, and that vector is also its priority. The upper four bits of the vector form its priority class. The block holds the pending requests, the set of vectors whose handlers are in progress, a task-priority threshold that software writes, and a global enable flag.

From the threshold and the in-service set the block derives a read-only processor priority: the larger of the threshold and the highest in-service vector. The highest pending vector is offered on the request line only if its class is strictly above the class of the processor priority and the global enable is set. When the core acknowledges an offered vector, that vector moves from pending to in-service and the global enable drops. This blocks further delivery until software sets the enable again. If software sets the enable inside a handler, a request of a higher class can preempt that handler, so handlers nest by class. An end-of-interrupt strobe retires the highest in-service vector.

Top module: `prio_intr_gate`

## Requirements
- R1: After reset the request line is low, the offered vector is 0, the processor priority is 0, the global enable is clear, the threshold is 0, and no vector is pending or in service.
- R2: A pulse on raise bit n (n from 16 to 255) makes vector n pending from the next cycle. `vec_o` always shows the highest pending vector number, or 0 when none is pending.
- R3: `irq_o` is high only when the enable is set, a vector is pending, and bits [7:4] of the highest pending vector are strictly greater than bits [7:4] of the processor priority. An equal class does not deliver.
- R4: `ppr_o` equals the larger of the threshold and the highest in-service vector number, using 0 when the in-service set is empty. A threshold write takes effect in the next cycle.
- R5: Raise pulses on vectors 0 to 15 are ignored. Such vectors never become pending, never appear on `vec_o` and never raise `irq_o`.
- R6: An `ack_i` in a cycle where `irq_o` is high clears the offered vector from pending, adds it to the in-service set and clears the enable, so `irq_o` is low in the next cycle. An `ack_i` while `irq_o` is low changes nothing.
- R7: An `eoi_i` pulse removes the highest in-service vector. The processor priority then falls back to the next in-service vector or to the threshold.
- R8: While the enable is clear, `irq_o` stays low. In the cycle after the enable is written to 1, a pending vector whose class beats the processor priority raises `irq_o`, including inside a running handler.
- R9: If an enable write and a delivering acknowledge fall in the same cycle, the acknowledge wins and the enable ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raise_i | input | 256 | One pulse bit per vector; marks that vector pending |
| ack_i | input | 1 | Core accepts the offered vector |
| eoi_i | input | 1 | End of interrupt; retires the highest in-service vector |
| ie_we_i | input | 1 | Write strobe for the global enable |
| ie_wval_i | input | 1 | Value written to the global enable |
| tpr_we_i | input | 1 | Write strobe for the task-priority threshold |
| tpr_wdata_i | input | 8 | New threshold value |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 8 | Highest pending vector (0 when none) |
| ppr_o | output | 8 | Derived processor priority |

## Verification
On every cycle, the assertions check four things. A delivering acknowledge drops the request in the next cycle and lifts the processor priority to at least the delivered class. A reserved vector is never requested. A threshold write puts a floor under the processor priority. An end-of-interrupt with no acknowledge or threshold write never raises the priority. The bench's scenarios are the only place where several things show up: the exact choice of the highest vector, the strict rejection of an equal class, the exact fall-back value after an end-of-interrupt, the ignored acknowledge, and preemption that becomes possible once the enable is set again inside a handler. Its model compares all three outputs after every cycle of directed and random traffic.

// File: rtl/prio_intr_pkg.sv
package prio_intr_pkg;

    localparam int unsigned DEF_VEC_W   = 8;
    localparam int unsigned DEF_CLASS_W = 4;
    localparam int unsigned DEF_RSVD    = 16;

endpackage

// File: rtl/prio_intr_msb.sv
module prio_intr_msb #(
    parameter int unsigned N = 256,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] bits_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);

    // Scan upward; the last set bit seen is the highest one.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_intr_gate.sv
module prio_intr_gate
    import prio_intr_pkg::*;
#(
    parameter  int unsigned VEC_W   = DEF_VEC_W,
    parameter  int unsigned CLASS_W = DEF_CLASS_W,
    parameter  int unsigned RSVD    = DEF_RSVD,
    localparam int unsigned NUM_VEC = 1 << VEC_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_VEC-1:0] raise_i,
    input  logic               ack_i,
    input  logic               eoi_i,
    input  logic               ie_we_i,
    input  logic               ie_wval_i,
    input  logic               tpr_we_i,
    input  logic [VEC_W-1:0]   tpr_wdata_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [VEC_W-1:0]   ppr_o
);

    localparam int unsigned CLS_HI = VEC_W - 1;
    localparam logic [NUM_VEC-1:0] KEEP_MASK = {NUM_VEC{1'b1}} << RSVD;

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] isr;
        logic [VEC_W-1:0]   tpr;
        logic               ie;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic             pend_any_w, isr_any_w;
    logic [VEC_W-1:0] pend_top_w, isr_top_w;
    logic [VEC_W-1:0] ppr_w;
    logic             offer_w, take_w;

    prio_intr_msb #(.N(NUM_VEC), .W(VEC_W)) u_pend_msb (
        .bits_i  (st_q.pend),
        .found_o (pend_any_w),
        .idx_o   (pend_top_w)
    );

    prio_intr_msb #(.N(NUM_VEC), .W(VEC_W)) u_isr_msb (
        .bits_i  (st_q.isr),
        .found_o (isr_any_w),
        .idx_o   (isr_top_w)
    );

    always_comb begin
        // Processor priority: larger of threshold and active handler.
        ppr_w   = (st_q.tpr > isr_top_w) ? st_q.tpr : isr_top_w;
        offer_w = st_q.ie && pend_any_w &&
                  (pend_top_w[CLS_HI -: CLASS_W] > ppr_w[CLS_HI -: CLASS_W]);
        take_w  = ack_i && offer_w;

        st_d = st_q;
        if (take_w) begin
            st_d.pend[pend_top_w] = 1'b0;
        end
        st_d.pend = st_d.pend | (raise_i & KEEP_MASK);

        if (eoi_i && isr_any_w) begin
            st_d.isr[isr_top_w] = 1'b0;
        end
        if (take_w) begin
            st_d.isr[pend_top_w] = 1'b1;
        end

        if (ie_we_i) begin
            st_d.ie = ie_wval_i;
        end
        if (take_w) begin
            st_d.ie = 1'b0;
        end

        if (tpr_we_i) begin
            st_d.tpr = tpr_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = offer_w;
    assign vec_o = pend_top_w;
    assign ppr_o = ppr_w;

    AST_ACK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=> !irq_o); // R6

    AST_ACK_LIFTS_PPR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=> (ppr_o[CLS_HI -: CLASS_W] >= $past(vec_o[CLS_HI -: CLASS_W]))); // R4

    AST_NO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (vec_o >= VEC_W'(RSVD))); // R5

    AST_TPR_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(tpr_we_i) && $past(rst_ni)) |-> (ppr_o >= $past(tpr_wdata_i))); // R4

    AST_EOI_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_i && !ack_i && !tpr_we_i) |=> (ppr_o <= $past(ppr_o))); // R7

endmodule

// File: tb/tb_prio_intr_gate.sv
module tb_prio_intr_gate;

    localparam int NV = 256;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [NV-1:0] raise_i = '0;
    logic          ack_i = 1'b0;
    logic          eoi_i = 1'b0;
    logic          ie_we_i = 1'b0;
    logic          ie_wval_i = 1'b0;
    logic          tpr_we_i = 1'b0;
    logic [7:0]    tpr_wdata_i = '0;
    logic          irq_o;
    logic [7:0]    vec_o;
    logic [7:0]    ppr_o;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    bit [NV-1:0] m_pend, m_isr;
    bit [7:0]    m_tpr;
    bit          m_ie;

    always #10 clk_i = ~clk_i;

    prio_intr_gate dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .raise_i(raise_i), .ack_i(ack_i),
        .eoi_i(eoi_i), .ie_we_i(ie_we_i), .ie_wval_i(ie_wval_i),
        .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i),
        .irq_o(irq_o), .vec_o(vec_o), .ppr_o(ppr_o)
    );

    function automatic int top_bit(bit [NV-1:0] v);
        int r = -1;
        for (int i = 0; i < NV; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic int exp_ppr();
        int a = top_bit(m_isr);
        if (a < 0) a = 0;
        return (int'(m_tpr) > a) ? int'(m_tpr) : a;
    endfunction

    function automatic int exp_vec();
        int p = top_bit(m_pend);
        return (p < 0) ? 0 : p;
    endfunction

    function automatic bit exp_irq();
        int p = top_bit(m_pend);
        if (!m_ie || p < 0) return 1'b0;
        return (p >> 4) > (exp_ppr() >> 4);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_check();
        chk("R3 irq vs model", int'(irq_o), int'(exp_irq()));
        chk("R2 vec vs model", int'(vec_o), exp_vec());
        chk("R4 ppr vs model", int'(ppr_o), exp_ppr());
    endtask

    task automatic model_reset();
        m_pend = '0; m_isr = '0; m_tpr = '0; m_ie = 1'b0;
    endtask

    // Drive at negedge, advance one edge, update the model, check at next negedge.
    task automatic step(input bit [NV-1:0] r, input bit a, input bit e,
                        input bit iw, input bit iv, input bit tw, input bit [7:0] td);
        bit take;
        int pt, it;
        raise_i = r; ack_i = a; eoi_i = e; ie_we_i = iw; ie_wval_i = iv;
        tpr_we_i = tw; tpr_wdata_i = td;
        take = a && exp_irq();
        pt = top_bit(m_pend);
        it = top_bit(m_isr);
        @(posedge clk_i);
        if (take) m_pend[pt] = 1'b0;
        for (int i = 16; i < NV; i++) if (r[i]) m_pend[i] = 1'b1;
        if (e && it >= 0) m_isr[it] = 1'b0;
        if (take) m_isr[pt] = 1'b1;
        if (iw) m_ie = iv;
        if (take) m_ie = 1'b0;
        if (tw) m_tpr = td;
        @(negedge clk_i);
        raise_i = '0; ack_i = 0; eoi_i = 0; ie_we_i = 0; tpr_we_i = 0;
        model_check();
    endtask

    function automatic bit [NV-1:0] one(int v);
        bit [NV-1:0] r = '0;
        r[v] = 1'b1;
        return r;
    endfunction

    task automatic expect3(string tag, bit irq, int vec, int ppr);
        chk({tag, " irq"}, int'(irq_o), int'(irq));
        chk({tag, " vec"}, int'(vec_o), vec);
        chk({tag, " ppr"}, int'(ppr_o), ppr);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk_i);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=<150000", cyc_cnt);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk_i);
        expect3("R1 reset", 1'b0, 0, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        expect3("R1 after release", 1'b0, 0, 0);

        step('0, 0, 0, 1, 1, 0, 0);
        expect3("R8 enable no pending", 1'b0, 0, 0);
        step(one(5) | one(15), 0, 0, 0, 0, 0, 0);
        expect3("R5 reserved ignored", 1'b0, 0, 0);
        step(one(8'h40) | one(8'h35), 0, 0, 0, 0, 0, 0);
        expect3("R2 highest offered", 1'b1, 8'h40, 0);
        step('0, 0, 0, 0, 0, 1, 8'h45);
        expect3("R3 equal class blocked", 1'b0, 8'h40, 8'h45);
        step('0, 0, 0, 0, 0, 1, 8'h3F);
        expect3("R3 lower threshold class", 1'b1, 8'h40, 8'h3F);
        step('0, 1, 0, 0, 0, 0, 0);
        expect3("R6 ack delivers", 1'b0, 8'h35, 8'h40);
        step(one(8'h90), 0, 0, 0, 0, 0, 0);
        expect3("R8 enable clear blocks", 1'b0, 8'h90, 8'h40);
        step('0, 0, 0, 1, 1, 0, 0);
        expect3("R8 nested preempt", 1'b1, 8'h90, 8'h40);
        step('0, 1, 0, 1, 1, 0, 0);
        expect3("R9 ack beats enable write", 1'b0, 8'h35, 8'h90);
        step(one(8'h95), 0, 0, 1, 1, 0, 0);
        expect3("R3 same class as active", 1'b0, 8'h95, 8'h90);
        step('0, 0, 1, 0, 0, 0, 0);
        expect3("R7 eoi falls back", 1'b1, 8'h95, 8'h40);
        step('0, 0, 0, 0, 0, 1, 8'hF0);
        expect3("R4 threshold above", 1'b0, 8'h95, 8'hF0);
        step('0, 1, 0, 0, 0, 0, 0);
        expect3("R6 ack ignored", 1'b0, 8'h95, 8'hF0);
        step('0, 0, 0, 0, 0, 1, 8'h00);
        step('0, 0, 1, 0, 0, 0, 0);
        expect3("R7 eoi to empty", 1'b1, 8'h95, 8'h00);

        for (int n = 0; n < 4000; n++) begin
            bit [NV-1:0] r = '0;
            bit [7:0] td;
            if ($urandom_range(0, 3) == 0) r[$urandom_range(0, NV-1)] = 1'b1;
            td = 8'($urandom_range(0, 8'hA0));
            step(r, $urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 9) == 0, td);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule